// File: doc/BRIEF.md
# Indirect MDIO Management Bridge

This block gives a host processor access to the management side of a two-channel Ethernet port through three host-visible words: a data word, a control word and a ready/status word. The host first places an operand in the data word. It then writes the control word, which names an internal location and carries a write-enable flag. That write starts the access at once. Each channel has one configuration location, which holds the MDIO enable and the MDC divider. Each channel also has two MDIO locations. One stores the write data for the next PHY write. The other launches a Clause 22 frame on the shared MDIO bus.

The serial clock MDC is generated from the host clock by the divider of the launching channel. The frame engine shifts the whole frame out and, for reads, captures the PHY's 16-bit reply back into the data word. Completion is reported by per-channel ready bits that the host polls in the status word.

Top module: `mgmt_bridge`

## Requirements
- R1: The data word is at host offset 13, the control word at 14 and the status word at 15 (base 0). After reset the data, control and status words all read 0, MDC is low and MDIO is not driven. A host write to the data word reads back unchanged.
- R2: A control write with bit 15 set and location 0x340 (channel 0) or 0x740 (channel 1) works as follows. It copies data word bit 6 (MDIO enable) and bits 5:0 (divider) into that channel's configuration. It sets the channel's configuration-ready bit, status bit 6 for channel 0 or bit 10 for channel 1, by the next clock.
- R3: The same control write with bit 15 clear returns that channel's configuration in the data word, zero-extended with enable at bit 6. It also sets the configuration-ready bit.
- R4: While a frame runs, MDC has a period of 2 × (divider + 1) host clocks, using the launching channel's divider. MDC is low whenever no frame runs.
- R5: A control write with bit 15 set to location 0x3B0 (channel 0) or 0x7B0 (channel 1) stores data bits 15:0 as that channel's PHY write data. The status word is left unchanged.
- R6: A control write to location 0x3B4 (channel 0) or 0x7B4 (channel 1) is a launch. If the channel's enable is set and no frame is running, it sends a 64-bit frame MSB first. The frame is 32 ones, then 01, then the opcode (01 write when bit 15 is set, 10 read when clear), then the PHY address from data bits 9:5, the register from data bits 4:0, then 10 and the write data. The channel's MDIO-ready bit (status bit 1 for channel 0, bit 5 for channel 1) reads 0 after the launch. It is set at the first clock edge after the final MDC falling edge.
- R7: On a read frame, MDIO is released from the first turnaround bit to the end of the frame. Sixteen bits are sampled on MDC rising edges, MSB first, and placed in data bits 15:0 with bits 31:16 zero.
- R8: The driven MDIO value changes only together with an MDC falling edge.
- R9: A launch on a channel whose enable is clear drives no frame. It sets that channel's MDIO-ready bit by the next clock.
- R10: A launch while a frame is running or finishing has no effect. No second frame follows, and the status word is unchanged.
- R11: When a read completes in the same clock as a host write to the data word, the read result is what the data word holds.
- R12: A control write to any other location leaves the data word and the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host word offset |
| host_wr | input | 1 | Host write strobe, one clock per write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr (combinational) |
| mdc | output | 1 | Management serial clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Two writers can load the data word in the same clock: a host write to the data word, and the capture of a finished PHY read. The bench provokes this by holding a data-word write on every clock during a read frame. It counts MDC falling edges at the port and keeps the write up through the clock right after the 64th falling edge, so that the last host write lands on the completion edge. The data word must then hold the PHY's reply, not the host pattern. A scoreboard also compares every frame bit-for-bit against the queued expectation, which exposes a second launch that should have been ignored.

// File: rtl/mgmt_bridge_pkg.sv
package mgmt_bridge_pkg;
   // host word offsets from the base
   localparam int OFS_DATA = 13;
   localparam int OFS_CTRL = 14;
   localparam int OFS_STAT = 15;
   // control word layout
   localparam int CTRL_WE_BIT = 15;
   localparam int LOC_LSB_W   = 10;   // location bits below the channel field
   localparam logic [LOC_LSB_W-1:0] LOC_CFG  = 10'h340;
   localparam logic [LOC_LSB_W-1:0] LOC_WDAT = 10'h3B0;
   localparam logic [LOC_LSB_W-1:0] LOC_LNCH = 10'h3B4;
   // configuration word layout
   localparam int MDIO_EN_BIT = 6;
   // status word layout: per-channel stride of four bits
   localparam int STAT_STRIDE  = 4;
   localparam int STAT_MDIO_B0 = 1;
   localparam int STAT_CFG_B0  = 6;
   // frame layout
   localparam int FRAME_BITS = 64;
   localparam int PRE_BITS   = 32;
   localparam int TA_POS     = PRE_BITS + 14;
   localparam int DAT_POS    = TA_POS + 2;
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             mdc,
   output logic             rise_p,
   output logic             fall_p
);
   generate
      if (DIV_W < 1 || DIV_W > 6) begin : g_bad_div
         $error("mgmt_mdc_gen: DIV_W must be 1..6");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;
   logic             tick;

   assign tick   = run && (cnt == div);
   assign rise_p = tick && !mdc;
   assign fall_p = tick && mdc;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (tick) begin
         cnt <= '0;
         mdc <= ~mdc;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mgmt_mdio_engine.sv
module mgmt_mdio_engine
   import mgmt_bridge_pkg::*;
#(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             req_rd,
   input  logic [4:0]       req_phy,
   input  logic [4:0]       req_reg,
   input  logic [15:0]      req_wdata,
   input  logic [DIV_W-1:0] req_div,
   input  logic             mdio_i,
   output logic             busy_o,
   output logic             done,
   output logic [15:0]      rdata,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe
);
   localparam int BIT_W = $clog2(FRAME_BITS);

   generate
      if (FRAME_BITS != 64 || PRE_BITS != 32) begin : g_bad_frame
         $error("mgmt_mdio_engine: frame layout must be 32+32 bits");
      end
   endgenerate

   logic                  busy;
   logic                  is_rd;
   logic [FRAME_BITS-1:0] sh;
   logic [BIT_W-1:0]      bitn;
   logic [DIV_W-1:0]      div_q;
   logic [BIT_W:0]        rise_cnt;
   logic                  rise_p, fall_p;

   mgmt_mdc_gen #(.DIV_W(DIV_W)) mdc_gen_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (busy),
      .div    (div_q),
      .mdc    (mdc),
      .rise_p (rise_p),
      .fall_p (fall_p)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         is_rd    <= 1'b0;
         sh       <= '0;
         bitn     <= '0;
         div_q    <= '0;
         rise_cnt <= '0;
         rdata    <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy && !done) begin
            busy     <= 1'b1;
            is_rd    <= req_rd;
            div_q    <= req_div;
            bitn     <= '0;
            rise_cnt <= '0;
            sh       <= {{PRE_BITS{1'b1}}, 2'b01, (req_rd ? 2'b10 : 2'b01),
                         req_phy, req_reg, 2'b10, req_wdata};
         end else if (busy) begin
            if (rise_p) begin
               rise_cnt <= rise_cnt + 1'b1;
               if (is_rd && bitn >= BIT_W'(DAT_POS))
                  rdata <= {rdata[14:0], mdio_i};
            end
            if (fall_p) begin
               if (bitn == BIT_W'(FRAME_BITS - 1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end else begin
                  bitn <= bitn + 1'b1;
                  sh   <= {sh[FRAME_BITS-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign busy_o  = busy || done;
   assign mdio_o  = busy ? sh[FRAME_BITS-1] : 1'b1;
   assign mdio_oe = busy && (!is_rd || bitn < BIT_W'(TA_POS));

   // R8
   mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));
   // R6
   frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rise_cnt == (BIT_W+1)'(FRAME_BITS)));
   // R4
   mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);
endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
   import mgmt_bridge_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DIV_W  = 6,
   parameter int ADDR_W = 8,
   parameter int BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   input  logic              eng_busy,
   input  logic              eng_done,
   input  logic [15:0]       eng_rdata,
   output logic              start,
   output logic              req_rd,
   output logic [4:0]        req_phy,
   output logic [4:0]        req_reg,
   output logic [15:0]       req_wdata,
   output logic [DIV_W-1:0]  req_div
);
   localparam int CH_W = $clog2(NUM_CH);

   generate
      if (NUM_CH != 2 && NUM_CH != 4) begin : g_bad_ch
         $error("mgmt_regfile: NUM_CH must be 2 or 4");
      end
      if (DIV_W < 1 || DIV_W > MDIO_EN_BIT) begin : g_bad_div
         $error("mgmt_regfile: divider field overlaps the enable bit");
      end
      if (BASE + OFS_STAT >= (1 << ADDR_W)) begin : g_bad_addr
         $error("mgmt_regfile: ADDR_W too narrow for BASE");
      end
   endgenerate

   logic [31:0]      data_q;
   logic [15:0]      ctrl_q;
   logic [31:0]      stat;
   logic [NUM_CH-1:0] cfg_en, cfg_rdy, mdio_rdy;
   logic [DIV_W-1:0] cfg_div [NUM_CH];
   logic [15:0]      wdat    [NUM_CH];
   logic [CH_W-1:0]  act_ch;
   logic             act_rd;

   // host decode
   logic                 wr_data, wr_ctrl, c_we;
   logic [CH_W-1:0]      c_ch;
   logic [LOC_LSB_W-1:0] c_loc;
   logic                 is_cfg, is_wdat, is_launch;
   logic [31:0]          cfg_word;

   assign wr_data   = host_wr && (host_addr == ADDR_W'(BASE + OFS_DATA));
   assign wr_ctrl   = host_wr && (host_addr == ADDR_W'(BASE + OFS_CTRL));
   assign c_we      = host_wdata[CTRL_WE_BIT];
   assign c_ch      = host_wdata[LOC_LSB_W +: CH_W];
   assign c_loc     = host_wdata[LOC_LSB_W-1:0];
   assign is_cfg    = wr_ctrl && (c_loc == LOC_CFG);
   assign is_wdat   = wr_ctrl && c_we && (c_loc == LOC_WDAT);
   assign is_launch = wr_ctrl && (c_loc == LOC_LNCH);
   assign cfg_word  = 32'(cfg_div[c_ch]) | (32'(cfg_en[c_ch]) << MDIO_EN_BIT);

   assign start     = is_launch && cfg_en[c_ch] && !eng_busy;
   assign req_rd    = !c_we;
   assign req_phy   = data_q[9:5];
   assign req_reg   = data_q[4:0];
   assign req_wdata = wdat[c_ch];
   assign req_div   = cfg_div[c_ch];

   // per-channel state
   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic             en_q, crdy_q, mrdy_q;
         logic [DIV_W-1:0] div_q;
         logic [15:0]      wd_q;
         logic             sel;

         assign sel = (c_ch == CH_W'(c));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q   <= 1'b0;
               crdy_q <= 1'b0;
               mrdy_q <= 1'b0;
               div_q  <= '0;
               wd_q   <= '0;
            end else begin
               if (is_cfg && sel) begin
                  crdy_q <= 1'b1;
                  if (c_we) begin
                     en_q  <= data_q[MDIO_EN_BIT];
                     div_q <= data_q[DIV_W-1:0];
                  end
               end
               if (is_wdat && sel)
                  wd_q <= data_q[15:0];
               if (is_launch && sel) begin
                  if (!en_q)
                     mrdy_q <= 1'b1;
                  else if (!eng_busy)
                     mrdy_q <= 1'b0;
               end
               if (eng_done && act_ch == CH_W'(c))
                  mrdy_q <= 1'b1;
            end
         end

         assign cfg_en[c]   = en_q;
         assign cfg_rdy[c]  = crdy_q;
         assign mdio_rdy[c] = mrdy_q;
         assign cfg_div[c]  = div_q;
         assign wdat[c]     = wd_q;
      end
   endgenerate

   always_comb begin
      stat = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         stat[STAT_MDIO_B0 + STAT_STRIDE*c] = mdio_rdy[c];
         stat[STAT_CFG_B0  + STAT_STRIDE*c] = cfg_rdy[c];
      end
   end

   // shared words; a finished read has the last say on the data word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         ctrl_q <= '0;
         act_ch <= '0;
         act_rd <= 1'b0;
      end else begin
         if (wr_data)
            data_q <= host_wdata;
         if (is_cfg && !c_we)
            data_q <= cfg_word;
         if (eng_done && act_rd)
            data_q <= {16'h0000, eng_rdata};
         if (wr_ctrl)
            ctrl_q <= host_wdata[15:0];
         if (start) begin
            act_ch <= c_ch;
            act_rd <= !c_we;
         end
      end
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == ADDR_W'(BASE + OFS_DATA))
         host_rdata = data_q;
      else if (host_addr == ADDR_W'(BASE + OFS_CTRL))
         host_rdata = {16'h0000, ctrl_q};
      else if (host_addr == ADDR_W'(BASE + OFS_STAT))
         host_rdata = stat;
   end

   // R2
   cfg_rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_cfg |=> cfg_rdy[$past(c_ch)]);
   // R9
   off_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_launch && !cfg_en[c_ch]) |=> mdio_rdy[$past(c_ch)]);
   // R10
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_launch && eng_busy && !eng_done) |=> (stat == $past(stat)));
   // R11
   rd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && act_rd && wr_data) |=> (data_q == {16'h0000, $past(eng_rdata)}));
endmodule

// File: rtl/mgmt_bridge.sv
module mgmt_bridge #(
   parameter int NUM_CH = 2,
   parameter int DIV_W  = 6,
   parameter int ADDR_W = 8,
   parameter int BASE   = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              mdc,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe
);
   logic             eng_busy, eng_done, start, req_rd;
   logic [15:0]      eng_rdata, req_wdata;
   logic [4:0]       req_phy, req_reg;
   logic [DIV_W-1:0] req_div;

   mgmt_regfile #(
      .NUM_CH (NUM_CH),
      .DIV_W  (DIV_W),
      .ADDR_W (ADDR_W),
      .BASE   (BASE)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_addr  (host_addr),
      .host_wr    (host_wr),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .eng_busy   (eng_busy),
      .eng_done   (eng_done),
      .eng_rdata  (eng_rdata),
      .start      (start),
      .req_rd     (req_rd),
      .req_phy    (req_phy),
      .req_reg    (req_reg),
      .req_wdata  (req_wdata),
      .req_div    (req_div)
   );

   mgmt_mdio_engine #(.DIV_W(DIV_W)) eng_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .req_rd    (req_rd),
      .req_phy   (req_phy),
      .req_reg   (req_reg),
      .req_wdata (req_wdata),
      .req_div   (req_div),
      .mdio_i    (mdio_i),
      .busy_o    (eng_busy),
      .done      (eng_done),
      .rdata     (eng_rdata),
      .mdc       (mdc),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe)
   );
endmodule

// File: tb/mgmt_bridge_tb_top.sv
`timescale 1ns/100ps
module mgmt_bridge_tb_top;
   localparam logic [7:0] A_DATA = 8'd13, A_CTRL = 8'd14, A_STAT = 8'd15;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [7:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        mdc, mdio_i = 1'b1, mdio_o, mdio_oe;

   always #2.5 clk = ~clk;

   mgmt_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

   typedef struct {
      bit        rd;
      bit [4:0]  phy;
      bit [4:0]  rg;
      bit [15:0] wd;
      int        div;
   } exp_t;

   exp_t        exp_q[$];
   int          checks = 0, failures = 0, frames = 0, oe_rises = 0, r8_bad = 0;
   int          nrise = 0;
   logic [15:0] phy_reply = 16'h0;
   bit          finished = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [31:0] v);
      @(negedge clk);
      host_addr = a;
      #1 v = host_rdata;
   endtask

   task automatic wait_stat(input int b, input string tag);
      logic [31:0] v;
      int n = 0;
      do begin
         hread(A_STAT, v);
         n++;
      end while (!v[b] && n < 5000);
      check(tag, 32'(v[b]), 32'd1);
   endtask

   function automatic logic [63:0] mk_frame(input exp_t e);
      return {32'hFFFF_FFFF, 2'b01, (e.rd ? 2'b10 : 2'b01), e.phy, e.rg, 2'b10, e.wd};
   endfunction

   // monitor: capture each frame at MDC rising edges and compare with the queue
   initial begin
      forever begin
         logic [63:0] outv, oev, expv;
         realtime t0, t1;
         exp_t e;
         @(posedge mdio_oe);
         oe_rises++;
         mdio_i = 1'b1;
         nrise = 0;
         for (int i = 0; i < 64; i++) begin
            @(posedge mdc);
            if (i == 0) t0 = $realtime;
            if (i == 1) t1 = $realtime;
            outv[63-i] = mdio_o;
            oev[63-i]  = mdio_oe;
            nrise++;
         end
         frames++;
         if (exp_q.size() == 0) begin
            check("R10 unexpected frame", 32'(frames), 32'(frames - 1));
         end else begin
            e = exp_q.pop_front();
            expv = mk_frame(e);
            // R4 MDC period in ns: 2*(div+1) clocks of 5 ns
            check("R4 mdc period", 32'(longint'(t1 - t0)), 32'(10 * (e.div + 1)));
            if (e.rd) begin
               // R6 header bits, R7 release from turnaround
               check("R6 read header", 32'(outv[63:18]), 32'(expv[63:18]));
               check("R6 read header hi", 32'(outv[63:50]), 32'(expv[63:50]));
               check("R7 oe during read", 32'({oev[63:18] == '1, oev[17:0] == '0}), 32'd3);
            end else begin
               check("R6 write frame lo", outv[31:0], expv[31:0]);
               check("R6 write frame hi", outv[63:32], expv[63:32]);
               check("R6 oe during write", 32'(oev == '1), 32'd1);
            end
         end
      end
   end

   // PHY model: present reply bits after MDC falls during the data phase
   always @(negedge mdc) begin
      if (nrise >= 48 && nrise < 64)
         mdio_i = phy_reply[63 - nrise];
   end

   // R8 watcher: the driven value may move only together with an MDC fall
   initial begin
      logic p_oe, p_o, p_mdc;
      p_oe = 1'b0; p_o = 1'b1; p_mdc = 1'b0;
      forever begin
         @(negedge clk);
         if (mdio_oe && p_oe && (mdio_o !== p_o) && !(p_mdc && !mdc)) r8_bad++;
         p_oe = mdio_oe; p_o = mdio_o; p_mdc = mdc;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, s0;
      int frames0, falls;
      logic prevm;
      exp_t e;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      hread(A_DATA, v); check("R1 data reset", v, 32'h0);
      hread(A_CTRL, v); check("R1 ctrl reset", v, 32'h0);
      hread(A_STAT, v); check("R1 status reset", v, 32'h0);
      check("R1 mdc/oe reset", 32'({mdc, mdio_oe}), 32'h0);

      hwrite(A_DATA, 32'h1234_5678);
      hread(A_DATA, v); check("R1 data readback", v, 32'h1234_5678);

      // R2 channel 0 configuration: enable, divider 2
      hwrite(A_DATA, 32'h42);
      hwrite(A_CTRL, 32'h8340);
      hread(A_STAT, v); check("R2 ch0 cfg ready", v, 32'h0000_0040);
      // R3 read back
      hwrite(A_DATA, 32'hFFFF_FFFF);
      hwrite(A_CTRL, 32'h0340);
      hread(A_DATA, v); check("R3 ch0 cfg readback", v, 32'h42);

      // R9 channel 1 with enable clear: launch completes at once
      hwrite(A_DATA, 32'h01);
      hwrite(A_CTRL, 32'h8740);
      hread(A_STAT, v); check("R2 ch1 cfg ready", v, 32'h0000_0440);
      frames0 = oe_rises;
      hwrite(A_DATA, 32'h20);
      hwrite(A_CTRL, 32'h07B4);
      hread(A_STAT, v); check("R9 disabled launch ready", v, 32'h0000_0460);
      repeat (40) @(negedge clk);
      check("R9 no frame while disabled", 32'(oe_rises), 32'(frames0));

      // enable channel 1, divider 1
      hwrite(A_DATA, 32'h41);
      hwrite(A_CTRL, 32'h8740);
      hwrite(A_DATA, 32'h41);
      hwrite(A_CTRL, 32'h0740);
      hread(A_DATA, v); check("R3 ch1 cfg readback", v, 32'h41);

      // R12 unknown location
      hread(A_STAT, s0);
      hwrite(A_CTRL, 32'h8123);
      hread(A_DATA, v); check("R12 data untouched", v, 32'h41);
      hread(A_STAT, v); check("R12 status untouched", v, s0);

      // R5 write-data load on channel 1
      hwrite(A_DATA, 32'h1140);
      hwrite(A_CTRL, 32'h87B0);
      hread(A_STAT, v); check("R5 status untouched", v, s0);

      // R6 write frame on channel 1: PHY 1, register 0
      e = '{rd: 1'b0, phy: 5'd1, rg: 5'd0, wd: 16'h1140, div: 1};
      exp_q.push_back(e);
      hwrite(A_DATA, 32'h20);
      hwrite(A_CTRL, 32'h87B4);
      hread(A_STAT, v); check("R6 ch1 mdio ready cleared", 32'(v[5]), 32'd0);
      wait_stat(5, "R6 ch1 mdio ready set");

      // R7 + R11 read on channel 0 with a data-word write on the completion edge
      phy_reply = 16'hBEEF;
      e = '{rd: 1'b1, phy: 5'd3, rg: 5'd2, wd: 16'h0, div: 2};
      exp_q.push_back(e);
      hwrite(A_DATA, 32'h62);
      hwrite(A_CTRL, 32'h03B4);
      host_addr = A_DATA; host_wdata = 32'h5A5A_5A5A; host_wr = 1'b1;
      falls = 0; prevm = mdc;
      while (falls < 64) begin
         @(negedge clk);
         if (prevm && !mdc) falls++;
         prevm = mdc;
      end
      @(negedge clk);
      host_wr = 1'b0;
      hread(A_DATA, v); check("R11 read result wins collision", v, 32'h0000_BEEF);
      hread(A_STAT, v); check("R6 ch0 mdio ready set", 32'(v[1]), 32'd1);

      // R4 with divider 0xA on channel 0
      hwrite(A_DATA, 32'h4A);
      hwrite(A_CTRL, 32'h8340);
      hwrite(A_DATA, 32'hA5C3);
      hwrite(A_CTRL, 32'h83B0);
      e = '{rd: 1'b0, phy: 5'd31, rg: 5'd17, wd: 16'hA5C3, div: 10};
      exp_q.push_back(e);
      hwrite(A_DATA, 32'h3F1);
      hwrite(A_CTRL, 32'h83B4);
      wait_stat(1, "R4 ch0 slow frame done");

      // R10 launch on channel 1 while channel 0 frame runs
      hwrite(A_DATA, 32'h40);
      hwrite(A_CTRL, 32'h8340);
      e = '{rd: 1'b0, phy: 5'd2, rg: 5'd5, wd: 16'hA5C3, div: 0};
      exp_q.push_back(e);
      hwrite(A_DATA, 32'h45);
      hwrite(A_CTRL, 32'h83B4);
      hread(A_STAT, s0);
      frames0 = oe_rises;
      hwrite(A_DATA, 32'h2A);
      hwrite(A_CTRL, 32'h07B4);
      hread(A_STAT, v); check("R10 status unchanged by busy launch", v, s0);
      wait_stat(1, "R10 ch0 frame done");
      repeat (400) @(negedge clk);
      check("R10 no second frame", 32'(oe_rises), 32'(frames0));
      check("R10 queue drained", 32'(exp_q.size()), 32'd0);

      check("R8 mdio changes only on mdc fall", 32'(r8_bad), 32'd0);
      check("R4 mdc idle low", 32'(mdc), 32'd0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule